// File: doc/BRIEF.md
# UART Interrupt Priority and Clear Controller

This block gathers the five interrupt conditions of a UART (line status error, receive data ready, receive timeout, transmitter empty and modem status change) into one prioritised identification value and one interrupt line. Each condition is caught by its own source latch when the condition rises. The latch is released by the register access that services that source. A small state machine holds the source being reported. Its state drives a 3-bit code, an active-low pending flag and the interrupt output.

The bus side is seen only as a read strobe, a write strobe and a register select. The block never returns data. It watches which register is touched so that it can apply each source's own clear rule. One rule needs particular care. The transmitter-empty source is released by a read of the identification register, but only when that read returns the transmitter-empty code. The clear decision uses the same registered state that drives the code seen by the reader. A read therefore cannot release a source it did not report.

State machine states: `ST_NONE` (nothing pending), `ST_LINE`, `ST_RXDATA` (receive data ready or timeout), `ST_TXEMPTY` and `ST_MODEM`. On every clock edge the machine moves to the highest-priority state whose source latch will be set after that edge. It falls back to `ST_NONE` when no latch remains set. Every transition between any two states is therefore possible, and each is taken one edge after the set or clear that causes it.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is asserted, and at the first sample after reset, `{id_code, pend_n}` reads 4'b0001 and `irq` is 0.
- R2: `pend_n` is 0 exactly when some source latch is set, and `irq` is always the inverse of `pend_n`. With no source set, the code is 3'b000. In the 4-bit view `{id_code, pend_n}`, the code sits in bits 3..1 and the pending flag in bit 0.
- R3: `id_code` reports only the highest-priority set source, using these codes: line status 3'b011, receive data ready or timeout 3'b010, transmitter empty 3'b001, modem status 3'b000. Line status has the highest priority and modem status the lowest.
- R4: The line status latch sets on a rising edge of `line_stat_cond` and clears on a read with `reg_sel` = `SEL_LINE` (default 5).
- R5: The receive data latch sets on a rising edge of `rx_avail_cond`. It clears on a read with `reg_sel` = `SEL_RXBUF` (default 0), or in any cycle in which `rx_avail_cond` is low.
- R6: The timeout latch sets on a rising edge of `rx_tmo_cond`, is reported with code 3'b010 and clears on a read with `reg_sel` = `SEL_RXBUF`.
- R7: The transmitter-empty latch sets on a rising edge of `tx_empty_cond` and clears on a write with `reg_sel` = `SEL_TXDATA` (default 0).
- R8: A read with `reg_sel` = `SEL_IDENT` (default 2) clears the transmitter-empty latch only when the code being output in that cycle is 3'b001. Otherwise it leaves every latch unchanged.
- R9: The modem latch sets on a rising edge of `modem_cond` and clears on a read with `reg_sel` = `SEL_MODEM` (default 6).
- R10: When a rising edge and a clear for the same source fall in the same cycle, the latch ends up set.
- R11: A condition held high does not set its latch again after the latch has been cleared. Only a new low-to-high transition does.
- R12: Reads at selects with no clear rule (1, 3, 4, 7), and writes at any select other than `SEL_TXDATA`, leave the reported value unchanged.
- R13: Every set or clear appears on the outputs at the first clock edge after the cycle in which the condition edge or the access was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stat_cond | input | 1 | Receiver line status error condition |
| rx_avail_cond | input | 1 | Receive FIFO level at or above trigger |
| rx_tmo_cond | input | 1 | Receive timeout condition |
| tx_empty_cond | input | 1 | Transmit holding register empty condition |
| modem_cond | input | 1 | Modem status change condition |
| rd_stb | input | 1 | Register read strobe, one cycle per access |
| wr_stb | input | 1 | Register write strobe, one cycle per access |
| reg_sel | input | SEL_W | Register select for the current access |
| id_code | output | 3 | Code of the highest-priority pending source |
| pend_n | output | 1 | 0 when an interrupt is pending |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with the defaults: a 3-bit select with the receive buffer and transmit data at 0, identification at 2, line status at 5 and modem status at 6. This leaves selects 1, 3, 4 and 7 free to show that accesses with no clear rule do nothing. With the default shared address 0, a write there clears transmitter-empty while a read there clears receive data and timeout, so the two directions are told apart at one select. The width is small enough that every select value can be reached, which lets the vector table cover every state of the machine and the identification-read qualification while a higher source masks transmitter-empty.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int NSRC = 5;

    localparam int SRC_LINE = 0;
    localparam int SRC_RXD  = 1;
    localparam int SRC_TMO  = 2;
    localparam int SRC_TXE  = 3;
    localparam int SRC_MDM  = 4;

    localparam logic [2:0] CODE_LINE = 3'b011;
    localparam logic [2:0] CODE_RXD  = 3'b010;
    localparam logic [2:0] CODE_TXE  = 3'b001;
    localparam logic [2:0] CODE_MDM  = 3'b000;

    typedef enum logic [2:0] {
        ST_NONE,
        ST_LINE,
        ST_RXDATA,
        ST_TXEMPTY,
        ST_MODEM
    } rep_state_e;

endpackage

// File: rtl/uirq_edge.sv
module uirq_edge #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/uirq_src_latch.sv
module uirq_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o,
    output logic pend_nx_o
);
    always_comb begin
        if (set_i)      pend_nx_o = 1'b1;
        else if (clr_i) pend_nx_o = 1'b0;
        else            pend_nx_o = pend_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_o <= 1'b0;
        else        pend_o <= pend_nx_o;
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
    parameter int SEL_W      = 3,
    parameter int SEL_RXBUF  = 0,
    parameter int SEL_TXDATA = 0,
    parameter int SEL_IDENT  = 2,
    parameter int SEL_LINE   = 5,
    parameter int SEL_MODEM  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_stat_cond,
    input  logic             rx_avail_cond,
    input  logic             rx_tmo_cond,
    input  logic             tx_empty_cond,
    input  logic             modem_cond,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [SEL_W-1:0] reg_sel,
    output logic [2:0]       id_code,
    output logic             pend_n,
    output logic             irq
);
    import uirq_pkg::*;

    localparam logic [SEL_W-1:0] A_RXBUF  = SEL_W'(SEL_RXBUF);
    localparam logic [SEL_W-1:0] A_TXDATA = SEL_W'(SEL_TXDATA);
    localparam logic [SEL_W-1:0] A_IDENT  = SEL_W'(SEL_IDENT);
    localparam logic [SEL_W-1:0] A_LINE   = SEL_W'(SEL_LINE);
    localparam logic [SEL_W-1:0] A_MODEM  = SEL_W'(SEL_MODEM);

    logic [NSRC-1:0] cond_vec;
    logic [NSRC-1:0] rise_vec;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] pend_nx;

    rep_state_e state_q;
    rep_state_e state_nx;

    logic rx_rd;

    always_comb begin
        cond_vec           = '0;
        cond_vec[SRC_LINE] = line_stat_cond;
        cond_vec[SRC_RXD]  = rx_avail_cond;
        cond_vec[SRC_TMO]  = rx_tmo_cond;
        cond_vec[SRC_TXE]  = tx_empty_cond;
        cond_vec[SRC_MDM]  = modem_cond;
    end

    uirq_edge #(.W(NSRC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (cond_vec),
        .rise  (rise_vec)
    );

    // Clear rules, one per source
    assign rx_rd = rd_stb && (reg_sel == A_RXBUF);

    always_comb begin
        clr_vec           = '0;
        clr_vec[SRC_LINE] = rd_stb && (reg_sel == A_LINE);
        clr_vec[SRC_RXD]  = rx_rd || !rx_avail_cond;
        clr_vec[SRC_TMO]  = rx_rd;
        clr_vec[SRC_TXE]  = (wr_stb && (reg_sel == A_TXDATA)) ||
                            (rd_stb && (reg_sel == A_IDENT) && (state_q == ST_TXEMPTY));
        clr_vec[SRC_MDM]  = rd_stb && (reg_sel == A_MODEM);
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        uirq_src_latch u_lat (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (rise_vec[g]),
            .clr_i     (clr_vec[g]),
            .pend_o    (pend_q[g]),
            .pend_nx_o (pend_nx[g])
        );
    end

    // Next reported source: highest priority among next latch values
    always_comb begin
        if (pend_nx[SRC_LINE])                          state_nx = ST_LINE;
        else if (pend_nx[SRC_RXD] || pend_nx[SRC_TMO])  state_nx = ST_RXDATA;
        else if (pend_nx[SRC_TXE])                      state_nx = ST_TXEMPTY;
        else if (pend_nx[SRC_MDM])                      state_nx = ST_MODEM;
        else                                            state_nx = ST_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NONE;
        else        state_q <= state_nx;
    end

    always_comb begin
        unique case (state_q)
            ST_LINE:    begin id_code = CODE_LINE; pend_n = 1'b0; end
            ST_RXDATA:  begin id_code = CODE_RXD;  pend_n = 1'b0; end
            ST_TXEMPTY: begin id_code = CODE_TXE;  pend_n = 1'b0; end
            ST_MODEM:   begin id_code = CODE_MDM;  pend_n = 1'b0; end
            default:    begin id_code = 3'b000;    pend_n = 1'b1; end
        endcase
        irq = !pend_n;
    end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
    parameter int SEL_W     = 3,
    parameter int SEL_IDENT = 2,
    parameter int SEL_LINE  = 5,
    parameter int SEL_MODEM = 6,
    parameter int NSRC      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_stat_cond,
    input logic             rx_avail_cond,
    input logic             rx_tmo_cond,
    input logic             tx_empty_cond,
    input logic             modem_cond,
    input logic             rd_stb,
    input logic [SEL_W-1:0] reg_sel,
    input logic [2:0]       id_code,
    input logic             pend_n,
    input logic             irq,
    input logic [NSRC-1:0]  pend_q
);
    logic [4:0] conds;
    logic [3:0] view;
    assign conds = {modem_cond, tx_empty_cond, rx_tmo_cond, rx_avail_cond, line_stat_cond};
    assign view  = {id_code, pend_n};

    // R1
    reset_value_chk: assert property (@(posedge clk)
        !rst_n |=> (!rst_n || (view == 4'b0001 && !irq)));

    // R2
    idle_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> (view == 4'b0001 && !irq));

    // R3
    line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[0] |-> (id_code == 3'b011 && !pend_n));

    // R4
    line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && reg_sel == SEL_W'(SEL_LINE) && view == 4'b0110 && $stable(conds))
        |=> (view != 4'b0110));

    // R8
    ident_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && reg_sel == SEL_W'(SEL_IDENT) && view == 4'b0010 && $stable(conds))
        |=> (view != 4'b0010));

    // R9
    modem_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && reg_sel == SEL_W'(SEL_MODEM) && view == 4'b0000 && $stable(conds))
        |=> (view != 4'b0000));

    // R10
    line_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_stat_cond) |=> (id_code == 3'b011 && irq));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
    .SEL_W     (SEL_W),
    .SEL_IDENT (SEL_IDENT),
    .SEL_LINE  (SEL_LINE),
    .SEL_MODEM (SEL_MODEM),
    .NSRC      (uirq_pkg::NSRC)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .line_stat_cond (line_stat_cond),
    .rx_avail_cond  (rx_avail_cond),
    .rx_tmo_cond    (rx_tmo_cond),
    .tx_empty_cond  (tx_empty_cond),
    .modem_cond     (modem_cond),
    .rd_stb         (rd_stb),
    .reg_sel        (reg_sel),
    .id_code        (id_code),
    .pend_n         (pend_n),
    .irq            (irq),
    .pend_q         (pend_q)
);

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ls_c = 1'b0, rd_c = 1'b0, to_c = 1'b0, te_c = 1'b0, ms_c = 1'b0;
    logic       rd_stb = 1'b0, wr_stb = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic [2:0] id_code;
    logic       pend_n, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .line_stat_cond(ls_c), .rx_avail_cond(rd_c), .rx_tmo_cond(to_c),
        .tx_empty_cond(te_c), .modem_cond(ms_c),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .reg_sel(reg_sel),
        .id_code(id_code), .pend_n(pend_n), .irq(irq)
    );

    // {cond[4:0] = ms,te,to,rd,ls ; rd ; wr ; sel[2:0] ; expected view[3:0] ; req[3:0]}
    localparam int NV = 27;
    localparam logic [17:0] VEC [NV] = '{
        {5'b00000, 1'b0, 1'b0, 3'd0, 4'b0001, 4'd1},   // R1 idle
        {5'b10000, 1'b0, 1'b0, 3'd0, 4'b0000, 4'd9},   // R9 modem set
        {5'b10000, 1'b1, 1'b0, 3'd6, 4'b0001, 4'd9},   // R9 modem cleared
        {5'b10000, 1'b0, 1'b0, 3'd0, 4'b0001, 4'd11},  // R11 held level
        {5'b11000, 1'b0, 1'b0, 3'd0, 4'b0010, 4'd7},   // R7 tx empty set
        {5'b11000, 1'b0, 1'b1, 3'd0, 4'b0001, 4'd7},   // R7 write clears
        {5'b01000, 1'b0, 1'b0, 3'd0, 4'b0001, 4'd11},  // R11
        {5'b00000, 1'b0, 1'b0, 3'd0, 4'b0001, 4'd2},   // R2
        {5'b01000, 1'b0, 1'b0, 3'd0, 4'b0010, 4'd13},  // R13 one edge
        {5'b01000, 1'b1, 1'b0, 3'd2, 4'b0001, 4'd8},   // R8 ident read clears
        {5'b00000, 1'b0, 1'b0, 3'd0, 4'b0001, 4'd2},   // R2
        {5'b01001, 1'b0, 1'b0, 3'd0, 4'b0110, 4'd3},   // R3 line over tx empty
        {5'b01001, 1'b1, 1'b0, 3'd2, 4'b0110, 4'd8},   // R8 masked, no clear
        {5'b01001, 1'b0, 1'b1, 3'd5, 4'b0110, 4'd12},  // R12 write at line sel
        {5'b01001, 1'b1, 1'b0, 3'd1, 4'b0110, 4'd12},  // R12 read at free sel
        {5'b01001, 1'b1, 1'b0, 3'd5, 4'b0010, 4'd4},   // R4 line cleared
        {5'b01011, 1'b0, 1'b0, 3'd0, 4'b0100, 4'd3},   // R3 rx data over tx empty
        {5'b01001, 1'b0, 1'b0, 3'd0, 4'b0010, 4'd5},   // R5 level drop
        {5'b01011, 1'b0, 1'b0, 3'd0, 4'b0100, 4'd5},   // R5 set again
        {5'b01011, 1'b1, 1'b0, 3'd0, 4'b0010, 4'd5},   // R5 buffer read
        {5'b01111, 1'b0, 1'b0, 3'd0, 4'b0100, 4'd6},   // R6 timeout code
        {5'b01111, 1'b1, 1'b0, 3'd0, 4'b0010, 4'd6},   // R6 buffer read clears
        {5'b01111, 1'b0, 1'b1, 3'd0, 4'b0001, 4'd7},   // R7
        {5'b00000, 1'b0, 1'b0, 3'd0, 4'b0001, 4'd2},   // R2
        {5'b00001, 1'b1, 1'b0, 3'd5, 4'b0110, 4'd10},  // R10 set wins
        {5'b00001, 1'b1, 1'b0, 3'd5, 4'b0001, 4'd4},   // R4
        {5'b00000, 1'b1, 1'b0, 3'd7, 4'b0001, 4'd12}   // R12
    };

    task automatic check(input logic [3:0] got, input logic [3:0] exp, input int req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic [17:0] v);
        {ms_c, te_c, to_c, rd_c, ls_c} = v[17:13];
        rd_stb  = v[12];
        wr_stb  = v[11];
        reg_sel = v[10:8];
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check({id_code, pend_n}, 4'b0001, 1, "view in reset");
        check({3'b000, irq}, 4'b0000, 1, "irq in reset");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            @(posedge clk);
            #2;
            check({id_code, pend_n}, VEC[i][7:4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
            // R2 irq mirrors pending
            check({3'b000, irq}, {3'b000, ~VEC[i][4]}, 2, $sformatf("irq vector %0d", i));
        end

        // R1 reset mid-run clears a pending source
        @(negedge clk);
        drive({5'b10000, 1'b0, 1'b0, 3'd0, 8'd0});
        @(negedge clk);
        check({id_code, pend_n}, 4'b0000, 9, "modem before reset");
        drive('0);
        rst_n = 1'b0;
        #1;
        check({id_code, pend_n}, 4'b0001, 1, "async reset view");
        @(negedge clk);
        rst_n = 1'b1;
        check({3'b000, irq}, 4'b0000, 1, "irq after reset");

        // R10 tx empty rise with clearing write in same cycle
        @(negedge clk);
        drive({5'b01000, 1'b0, 1'b1, 3'd0, 8'd0});
        @(posedge clk);
        #2;
        check({id_code, pend_n}, 4'b0010, 10, "tx empty set wins over write");

        // R13 nothing visible before the edge
        @(negedge clk);
        drive({5'b01001, 1'b0, 1'b0, 3'd0, 8'd0});
        #1;
        check({id_code, pend_n}, 4'b0010, 13, "before edge");
        @(posedge clk);
        #2;
        check({id_code, pend_n}, 4'b0110, 13, "after edge");

        @(negedge clk);
        drive('0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule